// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block switches one core power domain off and back on without software stepping through the work. A single keyed command word starts a power-down or a power-up. The sequencer then drives the reset release, the isolation clamp, three retention controls and an 8-bit power-switch enable bus in a fixed order. It waits a programmable number of timebase ticks after each drive step. At two points it polls the two status lines that the switch chain reports back: status A for the first chain and status D for the second.

The timebase is a free-running 64-bit tick count that comes from outside the block. Before each wait the sequencer captures the current count. It moves on once the unsigned difference between the current count and the captured count reaches the interval. The wait therefore stays correct when the counter wraps around. The interval is 800 ticks after reset, which is 200 us at a 4 MHz timebase. A command word can load a new interval while the block is idle.

The block leaves reset in the fully powered state. It shows `busy` while a sequence runs and pulses `done` when the sequence ends.

Top module: `pdseq_top`

## Requirements
- R1: After reset, all eight switch enables are 1, all three retention outputs are 1, isolation is 0, reset release is 1, and `busy` and `done` are 0.
- R2: A write is accepted only when `wr_data[31:24]` equals 0x27; any other key leaves the block unchanged. The operation field `wr_data[1:0]` takes these values:
  - 01: power down.
  - 10: power up.
  - 11: load the interval from `wr_data[23:8]`.
  - 00: no operation.
- R3: Power-down first drives reset release to 0, then isolation to 1, then DDR retention to 0, then SRAM pre-retention to 0, then SRAM retention to 0.
- R4: After those five steps, power-down waits until status D reads 0 and then until status A reads 0. No switch enable changes before both conditions have been seen.
- R5: Power-down then clears the switch enables one at a time, from bit 7 down to bit 0.
- R6: Power-up sets the switch enables one at a time, from bit 0 up to bit 7. It then waits for status A to read 1 and then for status D to read 1. No retention output changes before that.
- R7: Power-up then sets SRAM retention, then SRAM pre-retention, then DDR retention, then clears isolation, and last sets reset release.
- R8: The step after each drive step starts only once the tick count has advanced by at least the interval since that drive step. The interval is 800 after reset. With one tick per clock and an interval of N, consecutive drive steps are N+1 clocks apart.
- R9: Waits complete with the same spacing when the 64-bit tick count wraps through zero during a sequence.
- R10: A command written while a sequence is running, or while a request is still pending, is ignored.
- R11: `done` is high for exactly one clock at the end of each sequence, and `busy` is already 0 in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 64 | Free-running timebase count |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word: key, interval field and operation |
| stat_a | input | 1 | Switch chain A status (1 = on) |
| stat_d | input | 1 | Switch chain D status (1 = on) |
| sw_en | output | 8 | Staged power-switch enables |
| iso_en | output | 1 | Isolation clamp enable |
| rst_rel | output | 1 | Domain reset release |
| ret_sram | output | 1 | SRAM retention |
| ret_sram_pre | output | 1 | SRAM pre-retention |
| ret_ddr | output | 1 | DDR retention |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The power-down runs at the reset interval with both status lines held high past the retention steps. Releasing D while A stays high shows whether the block orders its polls or only looks at one line. The power-up runs with a loaded interval of 4, started just below the wrap point of the tick count. It checks that the clock spacing between steps is the same across zero, and it holds A, then D, low after the ramp to show that restore waits on both lines. A wrong-key write and a request made in the middle of a sequence are each expected to leave no trace in the outputs.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  localparam int NSW     = 8;
  localparam int CTL_W   = 17;
  localparam int NSTEP   = 15;
  localparam int STEP_W  = 4;

  localparam logic [4:0] POS_A    = 5'd8;
  localparam logic [4:0] POS_D    = 5'd9;
  localparam logic [4:0] POS_SRAM = 5'd12;
  localparam logic [4:0] POS_PRE  = 5'd13;
  localparam logic [4:0] POS_DDR  = 5'd14;
  localparam logic [4:0] POS_ISO  = 5'd15;
  localparam logic [4:0] POS_RST  = 5'd16;

  localparam logic [CTL_W-1:0] CTL_ON = 17'h170FF;
  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(NSTEP - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_WAIT, ST_POLL} st_t;

  typedef struct packed {
    logic       poll;
    logic [4:0] pos;
    logic       val;
  } step_t;

  function automatic step_t step_of(input logic up, input logic [STEP_W-1:0] idx);
    step_t s;
    s.poll = 1'b0;
    s.pos  = 5'd0;
    s.val  = up;
    if (!up) begin
      case (idx)
        4'd0: s.pos = POS_RST;
        4'd1: begin s.pos = POS_ISO; s.val = 1'b1; end
        4'd2: s.pos = POS_DDR;
        4'd3: s.pos = POS_PRE;
        4'd4: s.pos = POS_SRAM;
        4'd5: begin s.poll = 1'b1; s.pos = POS_D; end
        4'd6: begin s.poll = 1'b1; s.pos = POS_A; end
        default: s.pos = 5'(4'd14 - idx);
      endcase
    end else begin
      case (idx)
        4'd8:  begin s.poll = 1'b1; s.pos = POS_A; end
        4'd9:  begin s.poll = 1'b1; s.pos = POS_D; end
        4'd10: s.pos = POS_SRAM;
        4'd11: s.pos = POS_PRE;
        4'd12: s.pos = POS_DDR;
        4'd13: begin s.pos = POS_ISO; s.val = 1'b0; end
        4'd14: s.pos = POS_RST;
        default: s.pos = 5'(idx);
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/pdseq_cmd.sv
module pdseq_cmd #(
  parameter int          IVL_W   = 16,
  parameter int          DEF_IVL = 800,
  parameter logic [7:0]  KEY     = 8'h27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             busy,
  output logic             req_dn,
  output logic             req_up,
  output logic [IVL_W-1:0] ivl_q
);
  localparam int IVL_LSB = 8;

  logic       key_ok;
  logic [1:0] op;
  logic       take;

  assign key_ok = (wr_data[31:24] == KEY);
  assign op     = wr_data[1:0];
  assign take   = wr_en && key_ok && !busy && !(req_dn || req_up);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_dn <= 1'b0;
      req_up <= 1'b0;
      ivl_q  <= IVL_W'(DEF_IVL);
    end else begin
      req_dn <= take && (op == 2'b01);
      req_up <= take && (op == 2'b10);
      if (take && (op == 2'b11))
        ivl_q <= wr_data[IVL_LSB +: IVL_W];
    end
  end

  // R2: a wrong key raises no request and loads no interval
  a_r2_key_gate: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !key_ok) |=> (!(req_dn || req_up) && $stable(ivl_q)));
endmodule

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
  parameter int TS_W  = 64,
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [TS_W-1:0]  tick,
  input  logic [IVL_W-1:0] ivl,
  output logic             expired
);
  logic [TS_W-1:0] start_q;
  logic [TS_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst)          start_q <= '0;
    else if (capture) start_q <= tick;
  end

  // modular difference keeps the wait correct across counter wrap
  assign elapsed = tick - start_q;
  assign expired = elapsed >= {{(TS_W-IVL_W){1'b0}}, ivl};

  // R9: the captured start moves only on a capture
  a_r9_start_hold: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(start_q));
endmodule

// File: rtl/pdseq_engine.sv
module pdseq_engine
  import pdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_dn,
  input  logic             req_up,
  input  logic             expired,
  input  logic             stat_a,
  input  logic             stat_d,
  output logic [CTL_W-1:0] ctl_q,
  output logic             busy,
  output logic             done,
  output logic             capture
);
  st_t               st_q;
  logic              up_q;
  logic [STEP_W-1:0] idx_q;
  step_t             cur;
  logic              stat_hit;
  logic              last;
  logic              advance;

  assign cur      = step_of(up_q, idx_q);
  assign stat_hit = ((cur.pos == POS_A) ? stat_a : stat_d) == cur.val;
  assign last     = (idx_q == LAST_IDX);
  assign capture  = (st_q == ST_ACT) && !cur.poll;
  assign busy     = (st_q != ST_IDLE);
  assign advance  = ((st_q == ST_WAIT) && expired) || ((st_q == ST_POLL) && stat_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      up_q  <= 1'b0;
      idx_q <= '0;
      ctl_q <= CTL_ON;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_dn || req_up) begin
          up_q  <= req_up;
          idx_q <= '0;
          st_q  <= ST_ACT;
        end
        ST_ACT: if (cur.poll) st_q <= ST_POLL;
                else begin
                  ctl_q[cur.pos] <= cur.val;
                  st_q           <= ST_WAIT;
                end
        default: if (advance) begin
          if (last) begin
            st_q <= ST_IDLE;
            done <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_ACT;
          end
        end
      endcase
    end
  end

  // R8: a wait does not end before the interval has elapsed
  a_r8_hold_wait: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && !expired) |=> (st_q == ST_WAIT && $stable(ctl_q)));
  // R4 / R6: an unmet poll holds every control output
  a_r4_poll_gate: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_POLL && !stat_hit) |=> (st_q == ST_POLL && $stable(ctl_q)));
  // R10: no request is presented while a sequence runs
  a_r10_no_req_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(req_dn || req_up));
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top #(
  parameter int         TS_W    = 64,
  parameter int         IVL_W   = 16,
  parameter int         DEF_IVL = 800,
  parameter logic [7:0] KEY     = 8'h27
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TS_W-1:0] tick,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  input  logic            stat_a,
  input  logic            stat_d,
  output logic [7:0]      sw_en,
  output logic            iso_en,
  output logic            rst_rel,
  output logic            ret_sram,
  output logic            ret_sram_pre,
  output logic            ret_ddr,
  output logic            busy,
  output logic            done
);
  import pdseq_pkg::*;

  logic             req_dn, req_up, expired, capture;
  logic [IVL_W-1:0] ivl;
  logic [CTL_W-1:0] ctl;

  pdseq_cmd #(.IVL_W(IVL_W), .DEF_IVL(DEF_IVL), .KEY(KEY)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
    .req_dn(req_dn), .req_up(req_up), .ivl_q(ivl));

  pdseq_timer #(.TS_W(TS_W), .IVL_W(IVL_W)) u_timer (
    .clk(clk), .rst(rst), .capture(capture), .tick(tick), .ivl(ivl),
    .expired(expired));

  pdseq_engine u_eng (
    .clk(clk), .rst(rst), .req_dn(req_dn), .req_up(req_up), .expired(expired),
    .stat_a(stat_a), .stat_d(stat_d), .ctl_q(ctl), .busy(busy), .done(done),
    .capture(capture));

  assign sw_en        = ctl[NSW-1:0];
  assign ret_sram     = ctl[POS_SRAM];
  assign ret_sram_pre = ctl[POS_PRE];
  assign ret_ddr      = ctl[POS_DDR];
  assign iso_en       = ctl[POS_ISO];
  assign rst_rel      = ctl[POS_RST];

  // R5 / R6: switch enables move by at most one bit per clock
  a_r5_one_switch: assert property (@(posedge clk) disable iff (rst)
    $countones(sw_en ^ $past(sw_en)) <= 1);
  // R3 / R7: any switch off implies the clamp is on
  a_r3_iso_guard: assert property (@(posedge clk) disable iff (rst)
    (sw_en != 8'hFF) |-> iso_en);
  // R7: reset is never released while the clamp is on
  a_r7_rst_after_iso: assert property (@(posedge clk) disable iff (rst)
    rst_rel |-> !iso_en);
  // R11: completion pulse lasts one clock
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/sim_pdseq_top.sv
module sim_pdseq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] tick = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        stat_a = 1'b1, stat_d = 1'b1;
  logic [7:0]  sw_en;
  logic        iso_en, rst_rel, ret_sram, ret_sram_pre, ret_ddr, busy, done;

  pdseq_top u0 (.clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .stat_a(stat_a), .stat_d(stat_d), .sw_en(sw_en), .iso_en(iso_en), .rst_rel(rst_rel),
    .ret_sram(ret_sram), .ret_sram_pre(ret_sram_pre), .ret_ddr(ret_ddr),
    .busy(busy), .done(done));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, done_cnt = 0, done_busy_bad = 0;
  int ev_pos[$];
  int ev_t[$];
  logic [16:0] dctl, prev_ctl;

  always_comb begin
    dctl = '0;
    dctl[7:0] = sw_en;
    dctl[12] = ret_sram; dctl[13] = ret_sram_pre; dctl[14] = ret_ddr;
    dctl[15] = iso_en;   dctl[16] = rst_rel;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct { bit poll; int pos; bit val; } mstep_t;
  mstep_t mq[$];
  int m_ph = 0;
  longint unsigned m_start = 0;
  bit m_req = 0, m_req_up = 0, m_done = 0, m_busy_old, m_req_old, m_take, m_adv;
  int m_ivl = 800;
  bit [16:0] m_ctl = 17'h170FF;

  function automatic void push(bit p, int pos, bit v);
    mstep_t s; s.poll = p; s.pos = pos; s.val = v; mq.push_back(s);
  endfunction

  function automatic void build(bit up);
    mq.delete();
    if (!up) begin
      push(0,16,0); push(0,15,1); push(0,14,0); push(0,13,0); push(0,12,0);
      push(1,9,0); push(1,8,0);
      for (int k = 7; k >= 0; k--) push(0,k,0);
    end else begin
      for (int k = 0; k < 8; k++) push(0,k,1);
      push(1,8,1); push(1,9,1);
      push(0,12,1); push(0,13,1); push(0,14,1); push(0,15,0); push(0,16,1);
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_req = 0; m_done = 0; m_ivl = 800; m_ctl = 17'h170FF; mq.delete();
    end else begin
      m_busy_old = (m_ph != 0);
      m_req_old  = m_req;
      m_done = 0;
      m_adv  = 0;
      case (m_ph)
        0: if (m_req) begin build(m_req_up); m_ph = 1; end
        1: if (mq[0].poll) m_ph = 3;
           else begin m_ctl[mq[0].pos] = mq[0].val; m_start = tick; m_ph = 2; end
        2: m_adv = (tick - m_start) >= 64'(m_ivl);
        default: m_adv = (((mq[0].pos == 8) ? stat_a : stat_d) == mq[0].val);
      endcase
      if (m_adv) begin
        void'(mq.pop_front());
        if (mq.size() == 0) begin m_ph = 0; m_done = 1; end
        else m_ph = 1;
      end
      m_take = wr_en && (wr_data[31:24] == 8'h27) && !m_busy_old && !m_req_old;
      m_req    = m_take && (wr_data[1:0] == 2'b01 || wr_data[1:0] == 2'b10);
      m_req_up = (wr_data[1:0] == 2'b10);
      if (m_take && wr_data[1:0] == 2'b11) m_ivl = int'(wr_data[23:8]);
    end
  end

  always @(negedge clk) begin
    tick <= tick + 64'd1;
    if (!rst) begin
      cyc++;
      // R8: per-clock comparison against the reference model
      chk(dctl == m_ctl && busy == (m_ph != 0) && done == m_done, "R8 model",
          {dctl, busy, done}, {m_ctl, (m_ph != 0), m_done});
      for (int i = 0; i < 17; i++)
        if (dctl[i] != prev_ctl[i]) begin ev_pos.push_back(i); ev_t.push_back(cyc); end
      if (done) begin done_cnt++; if (busy) done_busy_bad++; end
    end
    prev_ctl = dctl;
  end

  task automatic write(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  int exp_dn[13] = '{16,15,14,13,12,7,6,5,4,3,2,1,0};
  int exp_up[13] = '{0,1,2,3,4,5,6,7,12,13,14,15,16};

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(dctl == 17'h170FF, "R1 outputs", dctl, 17'h170FF);
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);

    write(32'h2600_0001);
    write(32'h1500_0403);
    repeat (6) @(negedge clk);
    chk(!busy && dctl == 17'h170FF, "R2 bad key", {dctl, busy}, {17'h170FF, 1'b0});

    // power-down at the reset interval
    ev_pos.delete(); ev_t.delete();
    write(32'h2700_0001);
    while (ev_pos.size() < 5) @(negedge clk);
    repeat (900) @(negedge clk);
    chk(sw_en == 8'hFF && busy, "R4 wait D", sw_en, 8'hFF);
    stat_d = 1'b0;
    repeat (60) @(negedge clk);
    chk(sw_en == 8'hFF && busy, "R4 wait A", sw_en, 8'hFF);
    write(32'h2700_0002); // R10: request while busy
    stat_a = 1'b0;
    while (done_cnt < 1) @(negedge clk);
    chk(ev_pos.size() == 13, "R3 event count", ev_pos.size(), 13);
    for (int i = 0; i < 13 && i < ev_pos.size(); i++)
      chk(ev_pos[i] == exp_dn[i], (i < 5) ? "R3 order" : "R5 order", ev_pos[i], exp_dn[i]);
    chk(ev_t.size() > 1 && ev_t[1] - ev_t[0] == 801, "R8 default gap",
        (ev_t.size() > 1) ? ev_t[1] - ev_t[0] : -1, 801);
    repeat (10) @(negedge clk);
    chk(done_cnt == 1 && done_busy_bad == 0, "R11 pulse", done_cnt, 1);
    chk(!busy && sw_en == 8'h00, "R10 ignored", {busy, sw_en}, 0);

    // power-up with interval 4 across timebase wrap
    write(32'h2700_0403);
    @(posedge clk); #2 tick = 64'hFFFF_FFFF_FFFF_FFF0;
    ev_pos.delete(); ev_t.delete();
    write(32'h2700_0002);
    while (sw_en != 8'hFF) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(!ret_sram && busy, "R6 wait A", ret_sram, 0);
    stat_a = 1'b1;
    repeat (30) @(negedge clk);
    chk(!ret_sram && busy, "R6 wait D", ret_sram, 0);
    stat_d = 1'b1;
    while (done_cnt < 2) @(negedge clk);
    chk(ev_pos.size() == 13, "R6 event count", ev_pos.size(), 13);
    for (int i = 0; i < 13 && i < ev_pos.size(); i++)
      chk(ev_pos[i] == exp_up[i], (i < 8) ? "R6 order" : "R7 order", ev_pos[i], exp_up[i]);
    chk(ev_t.size() > 7 && ev_t[7] - ev_t[0] == 35, "R9 wrap gap",
        (ev_t.size() > 7) ? ev_t[7] - ev_t[0] : -1, 35);
    chk(ev_t.size() > 1 && ev_t[1] - ev_t[0] == 5, "R8 loaded gap",
        (ev_t.size() > 1) ? ev_t[1] - ev_t[0] : -1, 5);
    repeat (3) @(negedge clk);
    chk(tick < 64'h1000 && dctl == 17'h170FF && !busy, "R9 final", dctl, 17'h170FF);
    chk(done_busy_bad == 0, "R11 busy low", done_busy_bad, 0);
    summary();
    $finish;
  end
endmodule